// File: doc/BRIEF.md
# Ambient-Corrected Optical Sample Guard

This block sits behind the slot sequencer of a pulse-oximetry optical front end. Each converter code arrives tagged as lit (LED on) or dark (LED off), with a channel id and the edge-sample flag raised by the timing logic. The block holds each lit code until the next dark code arrives. It then emits one corrected result equal to lit minus dark. Each result carries quality flags and metrics, so downstream filtering can reject or down-weight a poor slot instead of averaging it in.

Codes that sit near either rail, and pairs sampled while the LED driver reports an open or short fault, produce invalid results. Results are clamped to a programmable window, and a clamped result is flagged as an outlier. Each result carries three metrics. The first is the change in ambient since the previous dark code. The second is the unclamped magnitude of the difference. The third is the running count of clipped codes in the burst. When a burst-end strobe arrives, the block reports the burst's clip total. It also raises a reject flag when that total exceeds a programmable limit.

The pairing logic is a two-state machine. In `ST_IDLE` no lit code is pending. In `ST_HOLD` one lit code is pending. The transitions are:
- *capture*: `ST_IDLE` to `ST_HOLD` on a lit code.
- *replace*: `ST_HOLD` to `ST_HOLD` on a lit code, which overwrites the pending one.
- *complete*: `ST_HOLD` to `ST_IDLE` on a dark code, which emits a result.
- *orphan*: `ST_IDLE` to `ST_IDLE` on a dark code, which emits nothing.
- *flush*: any state to `ST_IDLE` on burst end.

Top module: `ppg_ambient_guard`

## Requirements
- R1: A dark code (`smp_led_on`=0) accepted while a lit code is pending produces exactly one result, with `res_valid`=1 in the following cycle. The result has `res_chan` equal to the lit code's channel and a raw difference of lit minus dark, computed exactly as a signed value one bit wider than the code. A later lit code replaces a pending one. A dark code with nothing pending produces no result.
- R2: A code at or below `cfg_sat_lo`, or at or above `cfg_sat_hi`, is clipped. A result whose lit or dark code is clipped has `res_sat`=1 and `res_ok`=0. Otherwise `res_ok`=1 unless R7 applies.
- R3: A raw difference above `cfg_clamp_hi` is output as `cfg_clamp_hi`, and one below `cfg_clamp_lo` is output as `cfg_clamp_lo`. In both cases `res_outlier`=1, and the outlier flag alone does not clear `res_ok`.
- R4: `res_clips` is the number of clipped codes accepted in the current burst, counting both codes of this result. The count holds at its maximum rather than wrapping.
- R5: `res_resid` is the absolute difference between this dark code and the previous dark code of the same burst. It is 0 for the first dark code of a burst. Orphan dark codes also update this history.
- R6: `res_energy` is the absolute value of the raw difference, taken before clamping.
- R7: If `led_fault` is high when either code of the pair is accepted, the result has `res_fault`=1 and `res_ok`=0.
- R8: `res_edge` is the OR of the edge flags of the two codes. It does not affect `res_ok`.
- R9: In the cycle after `burst_end`, `burst_done`=1 and `burst_clips` carries the burst's clip count. `burst_reject`=1 exactly when that count exceeds `cfg_clip_limit`. The clip count, the ambient history and any pending lit code are then cleared, and a sample offered in the same cycle as `burst_end` is dropped.
- R10: After reset, `res_valid`, `burst_done` and `burst_reject` are 0 and no lit code is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | A tagged code is offered this cycle |
| smp_code | input | CODE_W | Converter code |
| smp_led_on | input | 1 | 1 = lit slot code, 0 = dark ambient code |
| smp_chan | input | CH_W | Channel id of the code |
| smp_edge | input | 1 | Edge-sample flag from the timing logic |
| burst_end | input | 1 | Ends the current burst |
| led_fault | input | 1 | LED open or short fault active |
| cfg_sat_lo | input | CODE_W | Low clip threshold (inclusive) |
| cfg_sat_hi | input | CODE_W | High clip threshold (inclusive) |
| cfg_clamp_lo | input | CODE_W+1 | Signed lower bound of the result |
| cfg_clamp_hi | input | CODE_W+1 | Signed upper bound of the result |
| cfg_clip_limit | input | CLIP_W | Clip count the burst may reach without rejection |
| res_valid | output | 1 | Result strobe |
| res_chan | output | CH_W | Channel of the result |
| res_value | output | CODE_W+1 | Clamped signed corrected value |
| res_ok | output | 1 | Result is usable |
| res_sat | output | 1 | A code of the pair was clipped |
| res_outlier | output | 1 | Value was clamped |
| res_fault | output | 1 | LED fault during the pair |
| res_edge | output | 1 | Edge-sample flag carried through |
| res_resid | output | CODE_W | Ambient change since the previous dark code |
| res_energy | output | CODE_W | Unclamped magnitude of the difference |
| res_clips | output | CLIP_W | Running clip count of the burst |
| burst_done | output | 1 | Burst summary strobe |
| burst_reject | output | 1 | Burst exceeded the clip limit |
| burst_clips | output | CLIP_W | Clip total of the finished burst |

## Verification
The hardest situation to reach is a lit code arriving in the same cycle as `burst_end`. It must be dropped, left uncounted and not held, and the only ways to see that are the absence of a result and an unchanged clip total afterwards. The bench offers a clipped lit code together with the strobe. It then sends a dark code and confirms that no result appears, and closes a second burst to confirm a clip total of zero. The reject comparison is driven at its boundary by closing one burst whose count exceeds the limit and another whose count equals it.

// File: rtl/ppg_amb_pkg.sv
package ppg_amb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } pair_state_e;
endpackage

// File: rtl/ppg_code_guard.sv
module ppg_code_guard #(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] lo,
    input  logic [CODE_W-1:0] hi,
    output logic              clipped
);
    always_comb begin
        clipped = (code <= lo) || (code >= hi);
    end
endmodule

// File: rtl/ppg_pair_fsm.sv
module ppg_pair_fsm
    import ppg_amb_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              is_on,
    input  logic              flush,
    input  logic [CODE_W-1:0] code,
    input  logic [CH_W-1:0]   chan,
    input  logic              edge_flag,
    input  logic              fault,
    input  logic              clipped,
    output logic              fire,
    output logic [CODE_W-1:0] held_code,
    output logic [CH_W-1:0]   held_chan,
    output logic              held_edge,
    output logic              held_fault,
    output logic              held_clip
);
    pair_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take && is_on) state_d = ST_HOLD;
            ST_HOLD: if (take && !is_on) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        if (flush) state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            ST_IDLE: fire = 1'b0;
            ST_HOLD: fire = take && !is_on;
            default: fire = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_code  <= '0;
            held_chan  <= '0;
            held_edge  <= 1'b0;
            held_fault <= 1'b0;
            held_clip  <= 1'b0;
        end else if (take && is_on) begin
            held_code  <= code;
            held_chan  <= chan;
            held_edge  <= edge_flag;
            held_fault <= fault;
            held_clip  <= clipped;
        end
    end

    // R1: the hold state is only entered by a lit code that was accepted
    a_r1_hold_from_lit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && $past(state_q) == ST_IDLE) |-> $past(take && is_on));
    // R9: a flush always leaves the machine idle
    a_r9_flush_idle: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state_q == ST_IDLE);
endmodule

// File: rtl/ppg_burst_stats.sv
module ppg_burst_stats #(
    parameter int CODE_W = 12,
    parameter int CLIP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              is_off,
    input  logic              flush,
    input  logic [CODE_W-1:0] code,
    input  logic              clipped,
    input  logic [CLIP_W-1:0] limit,
    output logic [CLIP_W-1:0] clip_now,
    output logic [CODE_W-1:0] resid,
    output logic              done,
    output logic              reject,
    output logic [CLIP_W-1:0] total
);
    localparam logic [CLIP_W-1:0] CLIP_MAX = {CLIP_W{1'b1}};

    logic [CLIP_W-1:0] clip_q;
    logic [CODE_W-1:0] amb_q;
    logic              amb_have_q;

    always_comb begin
        clip_now = clip_q;
        if (take && clipped && clip_q != CLIP_MAX) clip_now = clip_q + 1'b1;
        if (!amb_have_q)        resid = '0;
        else if (code >= amb_q) resid = code - amb_q;
        else                    resid = amb_q - code;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clip_q     <= '0;
            amb_q      <= '0;
            amb_have_q <= 1'b0;
            done       <= 1'b0;
            reject     <= 1'b0;
            total      <= '0;
        end else if (flush) begin
            clip_q     <= '0;
            amb_have_q <= 1'b0;
            done       <= 1'b1;
            reject     <= clip_q > limit;
            total      <= clip_q;
        end else begin
            done   <= 1'b0;
            clip_q <= clip_now;
            if (take && is_off) begin
                amb_q      <= code;
                amb_have_q <= 1'b1;
            end
        end
    end

    // R4: within a burst the clip count never decreases
    a_r4_clip_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(flush) |-> clip_q >= $past(clip_q));
    // R9: after a flush the count restarts from zero
    a_r9_clip_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> clip_q == '0);
endmodule

// File: rtl/ppg_ambient_guard.sv
module ppg_ambient_guard #(
    parameter int CODE_W = 12,
    parameter int CH_W   = 2,
    parameter int CLIP_W = 8,
    localparam int DIFF_W = CODE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_valid,
    input  logic [CODE_W-1:0]        smp_code,
    input  logic                     smp_led_on,
    input  logic [CH_W-1:0]          smp_chan,
    input  logic                     smp_edge,
    input  logic                     burst_end,
    input  logic                     led_fault,
    input  logic [CODE_W-1:0]        cfg_sat_lo,
    input  logic [CODE_W-1:0]        cfg_sat_hi,
    input  logic signed [DIFF_W-1:0] cfg_clamp_lo,
    input  logic signed [DIFF_W-1:0] cfg_clamp_hi,
    input  logic [CLIP_W-1:0]        cfg_clip_limit,
    output logic                     res_valid,
    output logic [CH_W-1:0]          res_chan,
    output logic signed [DIFF_W-1:0] res_value,
    output logic                     res_ok,
    output logic                     res_sat,
    output logic                     res_outlier,
    output logic                     res_fault,
    output logic                     res_edge,
    output logic [CODE_W-1:0]        res_resid,
    output logic [CODE_W-1:0]        res_energy,
    output logic [CLIP_W-1:0]        res_clips,
    output logic                     burst_done,
    output logic                     burst_reject,
    output logic [CLIP_W-1:0]        burst_clips
);
    logic              take, clipped, fire;
    logic [CODE_W-1:0] held_code, resid;
    logic [CH_W-1:0]   held_chan;
    logic              held_edge, held_fault, held_clip;
    logic [CLIP_W-1:0] clip_now;

    assign take = smp_valid && !burst_end;

    ppg_code_guard #(.CODE_W(CODE_W)) u_guard (
        .code(smp_code), .lo(cfg_sat_lo), .hi(cfg_sat_hi), .clipped(clipped)
    );

    ppg_pair_fsm #(.CODE_W(CODE_W), .CH_W(CH_W)) u_pair (
        .clk(clk), .rst_n(rst_n), .take(take), .is_on(smp_led_on),
        .flush(burst_end), .code(smp_code), .chan(smp_chan),
        .edge_flag(smp_edge), .fault(led_fault), .clipped(clipped),
        .fire(fire), .held_code(held_code), .held_chan(held_chan),
        .held_edge(held_edge), .held_fault(held_fault), .held_clip(held_clip)
    );

    ppg_burst_stats #(.CODE_W(CODE_W), .CLIP_W(CLIP_W)) u_stats (
        .clk(clk), .rst_n(rst_n), .take(take), .is_off(!smp_led_on),
        .flush(burst_end), .code(smp_code), .clipped(clipped),
        .limit(cfg_clip_limit), .clip_now(clip_now), .resid(resid),
        .done(burst_done), .reject(burst_reject), .total(burst_clips)
    );

    logic signed [DIFF_W-1:0] raw, mag, clamped;
    logic                     is_outlier;

    always_comb begin
        raw = $signed({1'b0, held_code}) - $signed({1'b0, smp_code});
        mag = raw[DIFF_W-1] ? -raw : raw;
        is_outlier = 1'b1;
        if (raw > cfg_clamp_hi)      clamped = cfg_clamp_hi;
        else if (raw < cfg_clamp_lo) clamped = cfg_clamp_lo;
        else begin
            clamped    = raw;
            is_outlier = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_chan    <= '0;
            res_value   <= '0;
            res_ok      <= 1'b0;
            res_sat     <= 1'b0;
            res_outlier <= 1'b0;
            res_fault   <= 1'b0;
            res_edge    <= 1'b0;
            res_resid   <= '0;
            res_energy  <= '0;
            res_clips   <= '0;
        end else begin
            res_valid <= fire;
            if (fire) begin
                res_chan    <= held_chan;
                res_value   <= clamped;
                res_sat     <= held_clip || clipped;
                res_fault   <= held_fault || led_fault;
                res_ok      <= !(held_clip || clipped || held_fault || led_fault);
                res_outlier <= is_outlier;
                res_edge    <= held_edge || smp_edge;
                res_resid   <= resid;
                res_energy  <= mag[CODE_W-1:0];
                res_clips   <= clip_now;
            end
        end
    end

    // R1: a result always follows an accepted dark code
    a_r1_after_dark: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(smp_valid && !smp_led_on && !burst_end));
    // R2: clipped results are never usable
    a_r2_sat_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_sat) |-> !res_ok);
    // R7: faulted results are never usable
    a_r7_fault_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> !res_ok);
    // R3: value stays inside the programmed window
    a_r3_within_window: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(cfg_clamp_lo <= cfg_clamp_hi))
        |-> (res_value <= $past(cfg_clamp_hi) && res_value >= $past(cfg_clamp_lo)));
    // R9: the summary strobe follows a burst end
    a_r9_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        burst_done |-> $past(burst_end));
    // R9: reject only when the total exceeds the limit
    a_r9_reject_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_done && burst_reject) |-> burst_clips > $past(cfg_clip_limit));
endmodule

// File: tb/ppg_ambient_guard_bench.sv
module ppg_ambient_guard_bench;
    localparam int CODE_W = 12;
    localparam int CH_W   = 2;
    localparam int CLIP_W = 8;
    localparam int DIFF_W = CODE_W + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0, smp_led_on = 1'b0, smp_edge = 1'b0;
    logic burst_end = 1'b0, led_fault = 1'b0;
    logic [CODE_W-1:0] smp_code = '0;
    logic [CH_W-1:0] smp_chan = '0;
    logic [CODE_W-1:0] cfg_sat_lo = 12'd16, cfg_sat_hi = 12'd4080;
    logic signed [DIFF_W-1:0] cfg_clamp_lo = -13'sd1000, cfg_clamp_hi = 13'sd3000;
    logic [CLIP_W-1:0] cfg_clip_limit = 8'd2;
    logic res_valid, res_ok, res_sat, res_outlier, res_fault, res_edge;
    logic [CH_W-1:0] res_chan;
    logic signed [DIFF_W-1:0] res_value;
    logic [CODE_W-1:0] res_resid, res_energy;
    logic [CLIP_W-1:0] res_clips, burst_clips;
    logic burst_done, burst_reject;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ppg_ambient_guard #(.CODE_W(CODE_W), .CH_W(CH_W), .CLIP_W(CLIP_W)) u_ppg_ambient_guard (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .smp_led_on(smp_led_on), .smp_chan(smp_chan), .smp_edge(smp_edge),
        .burst_end(burst_end), .led_fault(led_fault), .cfg_sat_lo(cfg_sat_lo),
        .cfg_sat_hi(cfg_sat_hi), .cfg_clamp_lo(cfg_clamp_lo), .cfg_clamp_hi(cfg_clamp_hi),
        .cfg_clip_limit(cfg_clip_limit), .res_valid(res_valid), .res_chan(res_chan),
        .res_value(res_value), .res_ok(res_ok), .res_sat(res_sat),
        .res_outlier(res_outlier), .res_fault(res_fault), .res_edge(res_edge),
        .res_resid(res_resid), .res_energy(res_energy), .res_clips(res_clips),
        .burst_done(burst_done), .burst_reject(burst_reject), .burst_clips(burst_clips)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // offer one code; returns at the following falling edge, result registered
    task automatic offer(input logic on, input int code, input int ch,
                         input logic edg, input logic flt, input logic bend);
        @(negedge clk);
        smp_valid = 1'b1; smp_led_on = on; smp_code = code[CODE_W-1:0];
        smp_chan = ch[CH_W-1:0]; smp_edge = edg; led_fault = flt; burst_end = bend;
        @(negedge clk);
        smp_valid = 1'b0; smp_edge = 1'b0; led_fault = 1'b0; burst_end = 1'b0;
    endtask

    task automatic end_burst();
        @(negedge clk);
        burst_end = 1'b1;
        @(negedge clk);
        burst_end = 1'b0;
    endtask

    task automatic expect_res(input string req, input int ch, input int val,
                              input int ok, input int sat, input int outl,
                              input int resid, input int energy, input int clips);
        chk({req, " valid"}, res_valid, 1);
        chk({req, " chan"}, res_chan, ch);
        chk({req, " value"}, res_value, val);
        chk({req, " ok"}, res_ok, ok);
        chk({req, " sat"}, res_sat, sat);
        chk({req, " outlier"}, res_outlier, outl);
        chk({req, " resid"}, res_resid, resid);
        chk({req, " energy"}, res_energy, energy);
        chk({req, " clips"}, res_clips, clips);
    endtask

    task automatic t_reset();
        chk("R10 res_valid", res_valid, 0);
        chk("R10 burst_done", burst_done, 0);
        chk("R10 burst_reject", burst_reject, 0);
    endtask

    task automatic t_basic();
        offer(1, 2000, 1, 0, 0, 0);
        chk("R1 no result on lit", res_valid, 0);
        offer(0, 500, 0, 0, 0, 0);
        expect_res("R1 R5 R6 first pair", 1, 1500, 1, 0, 0, 0, 1500, 0);
        offer(1, 1000, 2, 0, 0, 0);
        offer(0, 600, 0, 0, 0, 0);
        expect_res("R1 R5 second pair", 2, 400, 1, 0, 0, 100, 400, 0);
        offer(1, 300, 3, 0, 0, 0);
        offer(0, 800, 0, 0, 0, 0);
        expect_res("R1 R6 negative", 3, -500, 1, 0, 0, 200, 500, 0);
    endtask

    task automatic t_clamp();
        offer(1, 4000, 0, 0, 0, 0);
        offer(0, 100, 0, 0, 0, 0);
        expect_res("R3 R6 clamp high", 0, 3000, 1, 0, 1, 700, 3900, 0);
        offer(1, 100, 1, 0, 0, 0);
        offer(0, 1500, 0, 0, 0, 0);
        expect_res("R3 R6 clamp low", 1, -1000, 1, 0, 1, 1400, 1400, 0);
    endtask

    task automatic t_saturation();
        end_burst();
        chk("R9 done", burst_done, 1);
        chk("R9 clips zero", burst_clips, 0);
        chk("R9 no reject", burst_reject, 0);
        offer(1, 4085, 2, 0, 0, 0);
        offer(0, 3000, 0, 0, 0, 0);
        expect_res("R2 R4 lit clipped", 2, 1085, 0, 1, 0, 0, 1085, 1);
        offer(1, 10, 2, 0, 0, 0);
        offer(0, 5, 0, 0, 0, 0);
        expect_res("R2 R4 both clipped", 2, 5, 0, 1, 0, 2995, 5, 3);
        end_burst();
        chk("R9 done over limit", burst_done, 1);
        chk("R9 total", burst_clips, 3);
        chk("R9 reject over limit", burst_reject, 1);
        offer(1, 2000, 0, 0, 0, 0);
        offer(0, 1000, 0, 0, 0, 0);
        expect_res("R9 R4 R5 cleared after burst", 0, 1000, 1, 0, 0, 0, 1000, 0);
    endtask

    task automatic t_fault_edge();
        offer(1, 2000, 1, 0, 1, 0);
        offer(0, 1000, 0, 0, 0, 0);
        chk("R7 fault flag", res_fault, 1);
        chk("R7 not ok", res_ok, 0);
        offer(1, 2000, 1, 0, 0, 0);
        offer(0, 1000, 0, 1, 0, 0);
        chk("R8 edge carried", res_edge, 1);
        chk("R8 still ok", res_ok, 1);
        chk("R7 no fault", res_fault, 0);
    endtask

    task automatic t_orphan_replace();
        end_burst();
        offer(0, 700, 0, 0, 0, 0);
        chk("R1 orphan dark no result", res_valid, 0);
        offer(1, 1500, 1, 0, 0, 0);
        offer(0, 900, 0, 0, 0, 0);
        expect_res("R5 orphan updates history", 1, 600, 1, 0, 0, 200, 600, 0);
        offer(1, 3000, 1, 0, 0, 0);
        offer(1, 1200, 2, 0, 0, 0);
        offer(0, 200, 0, 0, 0, 0);
        expect_res("R1 replace pending", 2, 1000, 1, 0, 0, 700, 1000, 0);
    endtask

    task automatic t_end_collision();
        end_burst();
        offer(1, 4090, 3, 0, 0, 1);
        chk("R9 done on collision", burst_done, 1);
        offer(0, 500, 0, 0, 0, 0);
        chk("R9 dropped lit not held", res_valid, 0);
        end_burst();
        chk("R9 dropped lit not counted", burst_clips, 0);
        offer(1, 4095, 0, 0, 0, 0);
        offer(0, 3, 0, 0, 0, 0);
        chk("R4 two clips", res_clips, 2);
        end_burst();
        chk("R9 total at limit", burst_clips, 2);
        chk("R9 no reject at limit", burst_reject, 0);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp();
        t_saturation();
        t_fault_edge();
        t_orphan_replace();
        t_end_collision();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule